// File: doc/BRIEF.md
# Zero-Length Encoding Sample Compressor

The block takes the samples of one channel's acquisition window and sends out only the parts near threshold crossings. Each sample is compared with a programmable threshold. A polarity input decides whether "over" means above the threshold or below it. Every over-threshold run is widened by a programmable number of earlier samples (look-back) and later samples (look-forward). The result is a good/skipped tag for each sample. Good regions that touch or overlap become one region.

When the window has been classified, the block sends a burst of 32-bit words. The first word is the size of the burst. Control words follow, and they alternate between skipped runs and good runs. Each control word carries the run length in samples. After each good control word come the samples of that run, two per word. The compressor accepts a new window only while `busy` is low. `busy` stays high from the end of a window until the last output word has been issued.

Top module: `zle_compressor`

## Requirements
- R1: A sample counts as over threshold when it is strictly greater than `thresh` with `neg_polarity`=0, or strictly less than `thresh` with `neg_polarity`=1. A sample equal to the threshold is never over.
- R2: The `lbk_len` samples before each over-threshold sample are good (`lbk_len` is clamped to LBK_MAX). The extension stops at the first sample of the window.
- R3: The `lfwd_len` samples after each over-threshold sample are good. The extension stops at the last sample of the window.
- R4: With both extension counts at zero, exactly the over-threshold samples are good. Every sample that is not good is skipped and is never transferred.
- R5: Good regions that overlap or touch are emitted as a single good run. Consecutive control words in a burst always alternate between skipped and good.
- R6: The first word of each burst is the number of words in the burst, counting itself, all control words and all sample words. The bursts for successive windows appear in window order.
- R7: A control word has bit 31 set to 1 for a good run and 0 for a skipped run. The run length in samples is in bits [LEN_W-1:0], and all other bits are zero. The runs appear in sample order and their lengths add up to the window length.
- R8: The samples of a good run follow its control word two per word. The earlier sample is zero-extended into bits [15:0] and the later one into bits [31:16]. In a run of odd length, bits [31:16] of the last word are zero.
- R9: `busy` goes high on the cycle after the window's last sample is accepted. Input is ignored while `busy` is high. A burst is issued on consecutive cycles with `out_valid` high and no gap, and `busy` is low again after its last word.
- R10: After reset, `out_valid` and `busy` are low.
- R11: Cycles with `in_valid` low inside a window are not counted as samples and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present on `in_sample` |
| in_sop | input | 1 | First sample of a window |
| in_eop | input | 1 | Last sample of a window |
| in_sample | input | SAMPLE_W | Sample value |
| thresh | input | SAMPLE_W | Threshold |
| neg_polarity | input | 1 | 1: under threshold counts as over |
| lbk_len | input | LBK_W | Look-back sample count |
| lfwd_len | input | LFWD_W | Look-forward sample count |
| busy | output | 1 | Window being finished or emitted; input ignored |
| out_valid | output | 1 | `out_word` holds a burst word |
| out_word | output | 32 | Size, control or packed sample word |

## Verification
Faults show up in different words of the burst:
- A wrong good/skipped decision in the delay line or in the forward counter changes the run list. The size word shows it first, on the first cycle of the burst, and the affected control word shows it a few cycles later.
- A lost pad or a wrong packing pointer moves every later sample word of the window, so the scoreboard fails from that word onward.
- A run that is never closed, or input that is wrongly accepted while `busy` is high, shows as missing or extra words after `busy` falls.

// File: rtl/zle_pkg.sv
package zle_pkg;
  localparam int WORD_W   = 32;
  localparam int HALF_W   = 16;
  localparam int KIND_BIT = 31;

  typedef enum logic [1:0] {
    DR_IDLE,
    DR_SIZE,
    DR_CTRL,
    DR_DATA
  } drain_st_t;
endpackage

// File: rtl/zle_sdp_ram.sv
module zle_sdp_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/zle_window_classifier.sv
module zle_window_classifier #(
  parameter int SAMPLE_W = 14,
  parameter int LBK_MAX  = 15,
  parameter int LBK_W    = $clog2(LBK_MAX + 1),
  parameter int LFWD_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_acc,
  input  logic                in_sop,
  input  logic                in_eop,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [SAMPLE_W-1:0] thresh,
  input  logic                neg_polarity,
  input  logic [LBK_W-1:0]    lbk_len,
  input  logic [LFWD_W-1:0]   lfwd_len,
  output logic                c_valid,
  output logic                c_good,
  output logic                c_sop,
  output logic                c_eop,
  output logic [SAMPLE_W-1:0] c_sample
);
  localparam int DEPTH = LBK_MAX + 1;

  // stage 0 is the oldest entry; new samples enter at DEPTH-1
  logic [DEPTH-1:0]    dv, dov, dsop, deop;
  logic [SAMPLE_W-1:0] dd [DEPTH];
  logic                flushing;
  logic [LFWD_W-1:0]   fcnt;

  logic                in_over, shift, lb_hit, good_now;
  logic [LBK_W-1:0]    lbk_eff;
  logic [LFWD_W-1:0]   fwd_eff;

  assign in_over = neg_polarity ? (in_sample < thresh) : (in_sample > thresh);
  assign shift   = in_acc | flushing;
  assign lbk_eff = (lbk_len > LBK_W'(LBK_MAX)) ? LBK_W'(LBK_MAX) : lbk_len;
  assign fwd_eff = dsop[0] ? '0 : fcnt;

  always_comb begin
    lb_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i <= int'(lbk_eff)) lb_hit = lb_hit | dov[i];
    end
  end

  assign good_now = lb_hit | (fwd_eff != '0);

  always_ff @(posedge clk) begin
    if (shift) begin
      for (int i = 0; i < DEPTH - 1; i++) dd[i] <= dd[i+1];
      dd[DEPTH-1] <= in_sample;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dv       <= '0;
      dov      <= '0;
      dsop     <= '0;
      deop     <= '0;
      flushing <= 1'b0;
      fcnt     <= '0;
      c_valid  <= 1'b0;
      c_good   <= 1'b0;
      c_sop    <= 1'b0;
      c_eop    <= 1'b0;
      c_sample <= '0;
    end else begin
      c_valid <= 1'b0;
      if (in_acc && in_eop) flushing <= 1'b1;
      if (shift) begin
        dv   <= {in_acc, dv[DEPTH-1:1]};
        dov  <= {in_acc & in_over, dov[DEPTH-1:1]};
        dsop <= {in_acc & in_sop, dsop[DEPTH-1:1]};
        deop <= {in_acc & in_eop, deop[DEPTH-1:1]};
        if (dv[0]) begin
          c_valid  <= 1'b1;
          c_good   <= good_now;
          c_sop    <= dsop[0];
          c_eop    <= deop[0];
          c_sample <= dd[0];
          if (dov[0])              fcnt <= lfwd_len;
          else if (fwd_eff != '0)  fcnt <= fwd_eff - 1'b1;
          else                     fcnt <= '0;
          if (deop[0]) flushing <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/zle_run_packer.sv
module zle_run_packer
  import zle_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int LEN_W    = 9,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                c_valid,
  input  logic                c_good,
  input  logic                c_sop,
  input  logic                c_eop,
  input  logic [SAMPLE_W-1:0] c_sample,
  output logic                run_we,
  output logic [ADDR_W-1:0]   run_waddr,
  output logic [WORD_W-1:0]   run_wdata,
  output logic                dat_we,
  output logic [ADDR_W-1:0]   dat_waddr,
  output logic [WORD_W-1:0]   dat_wdata,
  output logic [LEN_W-1:0]    run_cnt,
  output logic [LEN_W-1:0]    dat_cnt,
  output logic                done
);
  logic                cur_good, half, close_pend;
  logic [LEN_W-1:0]    cur_len;
  logic [SAMPLE_W-1:0] lo;

  function automatic logic [WORD_W-1:0] ctrl_word(input logic kind, input logic [LEN_W-1:0] len);
    ctrl_word = {kind, {(WORD_W-1-LEN_W){1'b0}}, len};
  endfunction

  function automatic logic [WORD_W-1:0] pair_word(input logic [SAMPLE_W-1:0] hi,
                                                   input logic [SAMPLE_W-1:0] low);
    pair_word = {{(HALF_W-SAMPLE_W){1'b0}}, hi, {(HALF_W-SAMPLE_W){1'b0}}, low};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      run_we     <= 1'b0;
      run_waddr  <= '0;
      run_wdata  <= '0;
      dat_we     <= 1'b0;
      dat_waddr  <= '0;
      dat_wdata  <= '0;
      run_cnt    <= '0;
      dat_cnt    <= '0;
      done       <= 1'b0;
      cur_good   <= 1'b0;
      cur_len    <= '0;
      half       <= 1'b0;
      lo         <= '0;
      close_pend <= 1'b0;
    end else begin
      run_we <= 1'b0;
      dat_we <= 1'b0;
      done   <= 1'b0;
      if (close_pend) begin
        run_we     <= 1'b1;
        run_waddr  <= run_cnt[ADDR_W-1:0];
        run_wdata  <= ctrl_word(cur_good, cur_len);
        run_cnt    <= run_cnt + 1'b1;
        if (cur_good && half) begin
          dat_we    <= 1'b1;
          dat_waddr <= dat_cnt[ADDR_W-1:0];
          dat_wdata <= pair_word('0, lo);
          dat_cnt   <= dat_cnt + 1'b1;
          half      <= 1'b0;
        end
        close_pend <= 1'b0;
        done       <= 1'b1;
      end else if (c_valid) begin
        if (c_sop) begin
          run_cnt  <= '0;
          dat_cnt  <= '0;
          cur_good <= c_good;
          cur_len  <= LEN_W'(1);
          half     <= c_good;
          lo       <= c_sample;
        end else if (c_good == cur_good) begin
          cur_len <= cur_len + 1'b1;
          if (c_good) begin
            if (half) begin
              dat_we    <= 1'b1;
              dat_waddr <= dat_cnt[ADDR_W-1:0];
              dat_wdata <= pair_word(c_sample, lo);
              dat_cnt   <= dat_cnt + 1'b1;
              half      <= 1'b0;
            end else begin
              lo   <= c_sample;
              half <= 1'b1;
            end
          end
        end else begin
          run_we    <= 1'b1;
          run_waddr <= run_cnt[ADDR_W-1:0];
          run_wdata <= ctrl_word(cur_good, cur_len);
          run_cnt   <= run_cnt + 1'b1;
          if (cur_good && half) begin
            dat_we    <= 1'b1;
            dat_waddr <= dat_cnt[ADDR_W-1:0];
            dat_wdata <= pair_word('0, lo);
            dat_cnt   <= dat_cnt + 1'b1;
          end
          half     <= 1'b0;
          cur_good <= c_good;
          cur_len  <= LEN_W'(1);
          if (c_good) begin
            lo   <= c_sample;
            half <= 1'b1;
          end
        end
        if (c_eop) close_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/zle_compressor.sv
module zle_compressor
  import zle_pkg::*;
#(
  parameter int SAMPLE_W    = 14,
  parameter int LBK_MAX     = 15,
  parameter int LBK_W       = $clog2(LBK_MAX + 1),
  parameter int LFWD_W      = 8,
  parameter int MAX_SAMPLES = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_sop,
  input  logic                in_eop,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [SAMPLE_W-1:0] thresh,
  input  logic                neg_polarity,
  input  logic [LBK_W-1:0]    lbk_len,
  input  logic [LFWD_W-1:0]   lfwd_len,
  output logic                busy,
  output logic                out_valid,
  output logic [31:0]         out_word
);
  localparam int LEN_W  = $clog2(MAX_SAMPLES + 1);
  localparam int ADDR_W = $clog2(MAX_SAMPLES);

  logic                acc;
  logic                c_valid, c_good, c_sop, c_eop;
  logic [SAMPLE_W-1:0] c_sample;
  logic                run_we, dat_we, done;
  logic [ADDR_W-1:0]   run_waddr, dat_waddr;
  logic [WORD_W-1:0]   run_wdata, dat_wdata, rq, dq;
  logic [LEN_W-1:0]    run_cnt, dat_cnt;

  drain_st_t           st, st_n;
  logic [LEN_W-1:0]    r_idx, r_idx_n, d_idx, d_idx_n, wleft, wleft_n, rlen;
  logic                ov_n, drain_end;
  logic [WORD_W-1:0]   ow_n;

  assign acc = in_valid & ~busy;

  zle_window_classifier #(
    .SAMPLE_W(SAMPLE_W), .LBK_MAX(LBK_MAX), .LBK_W(LBK_W), .LFWD_W(LFWD_W)
  ) u_cls (
    .clk(clk), .rst(rst), .in_acc(acc), .in_sop(in_sop), .in_eop(in_eop),
    .in_sample(in_sample), .thresh(thresh), .neg_polarity(neg_polarity),
    .lbk_len(lbk_len), .lfwd_len(lfwd_len),
    .c_valid(c_valid), .c_good(c_good), .c_sop(c_sop), .c_eop(c_eop), .c_sample(c_sample)
  );

  zle_run_packer #(
    .SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_pack (
    .clk(clk), .rst(rst), .c_valid(c_valid), .c_good(c_good), .c_sop(c_sop),
    .c_eop(c_eop), .c_sample(c_sample),
    .run_we(run_we), .run_waddr(run_waddr), .run_wdata(run_wdata),
    .dat_we(dat_we), .dat_waddr(dat_waddr), .dat_wdata(dat_wdata),
    .run_cnt(run_cnt), .dat_cnt(dat_cnt), .done(done)
  );

  // read addresses follow the next-state index so each read word is ready when consumed
  zle_sdp_ram #(.W(WORD_W), .DEPTH(MAX_SAMPLES), .AW(ADDR_W)) u_run_ram (
    .clk(clk), .we(run_we), .waddr(run_waddr), .wdata(run_wdata),
    .raddr(r_idx_n[ADDR_W-1:0]), .rdata(rq)
  );

  zle_sdp_ram #(.W(WORD_W), .DEPTH(MAX_SAMPLES), .AW(ADDR_W)) u_dat_ram (
    .clk(clk), .we(dat_we), .waddr(dat_waddr), .wdata(dat_wdata),
    .raddr(d_idx_n[ADDR_W-1:0]), .rdata(dq)
  );

  assign rlen = rq[LEN_W-1:0];

  always_comb begin
    st_n      = st;
    r_idx_n   = r_idx;
    d_idx_n   = d_idx;
    wleft_n   = wleft;
    ov_n      = 1'b0;
    ow_n      = '0;
    drain_end = 1'b0;
    case (st)
      DR_IDLE: begin
        if (done) begin
          st_n    = DR_SIZE;
          r_idx_n = '0;
          d_idx_n = '0;
        end
      end
      DR_SIZE: begin
        ov_n = 1'b1;
        ow_n = WORD_W'(1) + WORD_W'(run_cnt) + WORD_W'(dat_cnt);
        st_n = DR_CTRL;
      end
      DR_CTRL: begin
        ov_n = 1'b1;
        ow_n = rq;
        if (rq[KIND_BIT]) begin
          wleft_n = (rlen >> 1) + LEN_W'(rlen[0]);
          st_n    = DR_DATA;
        end else begin
          r_idx_n = r_idx + 1'b1;
          if (r_idx + 1'b1 == run_cnt) begin
            st_n      = DR_IDLE;
            drain_end = 1'b1;
          end
        end
      end
      DR_DATA: begin
        ov_n    = 1'b1;
        ow_n    = dq;
        d_idx_n = d_idx + 1'b1;
        wleft_n = wleft - 1'b1;
        if (wleft == LEN_W'(1)) begin
          r_idx_n = r_idx + 1'b1;
          if (r_idx + 1'b1 == run_cnt) begin
            st_n      = DR_IDLE;
            drain_end = 1'b1;
          end else begin
            st_n = DR_CTRL;
          end
        end
      end
      default: st_n = DR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= DR_IDLE;
      r_idx     <= '0;
      d_idx     <= '0;
      wleft     <= '0;
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      st        <= st_n;
      r_idx     <= r_idx_n;
      d_idx     <= d_idx_n;
      wleft     <= wleft_n;
      out_valid <= ov_n;
      out_word  <= ow_n;
      if (acc && in_eop)  busy <= 1'b1;
      else if (drain_end) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/zle_compressor_chk.sv
module zle_compressor_chk #(
  parameter int LEN_W       = 9,
  parameter int MAX_SAMPLES = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_eop,
  input logic             busy,
  input logic             out_valid,
  input logic [31:0]      out_word,
  input logic             run_we,
  input logic [31:0]      run_wdata,
  input logic [LEN_W-1:0] dat_cnt
);
  a_r9_busy_after_eop: assert property (@(posedge clk) disable iff (rst)
    (!busy && in_valid && in_eop) |=> busy);

  a_r9_out_only_in_drain: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(busy));

  a_r6_size_word_leads: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_word[31] == 1'b0 && out_word != 32'd0));

  a_r7_run_len_nonzero: assert property (@(posedge clk) disable iff (rst)
    run_we |-> (run_wdata[LEN_W-1:0] != '0));

  a_r8_data_within_depth: assert property (@(posedge clk) disable iff (rst)
    int'(dat_cnt) <= MAX_SAMPLES);
endmodule

bind zle_compressor zle_compressor_chk #(.LEN_W(LEN_W), .MAX_SAMPLES(MAX_SAMPLES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_eop(in_eop), .busy(busy),
  .out_valid(out_valid), .out_word(out_word), .run_we(run_we),
  .run_wdata(run_wdata), .dat_cnt(dat_cnt)
);

// File: tb/sim_zle_compressor.sv
module sim_zle_compressor;
  localparam int SW     = 14;
  localparam int LBKMAX = 15;
  localparam int LBKW   = 4;
  localparam int LFWDW  = 8;
  localparam int MAXS   = 256;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, neg_polarity = 1'b0;
  logic [SW-1:0]    in_sample = '0, thresh = '0;
  logic [LBKW-1:0]  lbk_len = '0;
  logic [LFWDW-1:0] lfwd_len = '0;
  logic busy, out_valid;
  logic [31:0] out_word;

  int n_tests = 0, n_fail = 0;
  int smp [MAXS];
  logic [31:0] qw [$];
  string       qt [$];

  always #10 clk = ~clk;

  zle_compressor #(.SAMPLE_W(SW), .LBK_MAX(LBKMAX), .LBK_W(LBKW), .LFWD_W(LFWDW),
                   .MAX_SAMPLES(MAXS)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_sample(in_sample), .thresh(thresh), .neg_polarity(neg_polarity),
    .lbk_len(lbk_len), .lfwd_len(lfwd_len), .busy(busy), .out_valid(out_valid),
    .out_word(out_word)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // monitor: scoreboard comparison of every emitted word
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (qw.size() == 0) begin
        check("R9", "unexpected extra word", out_word, 32'hxxxx_xxxx);
      end else begin
        automatic logic [31:0] e = qw.pop_front();
        automatic string t = qt.pop_front();
        check(t, "burst word", out_word, e);
      end
    end
  end

  // reference model: classify, build runs, push expected words
  task automatic expect_window(string tag, int n, bit neg, int thr, int lbk, int lfwd);
    bit ov [MAXS];
    bit gd [MAXS];
    int rs [MAXS];
    int rl [MAXS];
    bit rk [MAXS];
    int nr = 0, nd = 0;
    for (int i = 0; i < n; i++) ov[i] = neg ? (smp[i] < thr) : (smp[i] > thr);
    for (int i = 0; i < n; i++) begin
      gd[i] = 1'b0;
      for (int j = 0; j < n; j++)
        if (ov[j] && (i >= j - lbk) && (i <= j + lfwd)) gd[i] = 1'b1;
    end
    for (int i = 0; i < n; i++) begin
      if (i == 0 || gd[i] != gd[i-1]) begin
        rs[nr] = i; rl[nr] = 1; rk[nr] = gd[i]; nr++;
      end else rl[nr-1]++;
    end
    for (int r = 0; r < nr; r++) if (rk[r]) nd += (rl[r] + 1) / 2;
    qw.push_back(32'(1 + nr + nd)); qt.push_back({tag, "/R6"});
    for (int r = 0; r < nr; r++) begin
      qw.push_back({rk[r], 31'(rl[r])}); qt.push_back({tag, "/R7"});
      if (rk[r]) begin
        for (int k = 0; k < rl[r]; k += 2) begin
          automatic int lo = smp[rs[r] + k];
          automatic int hi = (k + 1 < rl[r]) ? smp[rs[r] + k + 1] : 0;
          qw.push_back({16'(hi), 16'(lo)}); qt.push_back({tag, "/R8"});
        end
      end
    end
  endtask

  task automatic run_window(string tag, int n, bit neg, int thr, int lbk, int lfwd,
                            bit gaps, bit poke);
    int t;
    expect_window(tag, n, neg, thr, lbk, lfwd);
    @(negedge clk);
    neg_polarity = neg; thresh = SW'(thr); lbk_len = LBKW'(lbk); lfwd_len = LFWDW'(lfwd);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 4 == 2)) begin
        in_valid = 1'b0; in_sample = 14'h3fff; in_sop = 1'b1; in_eop = 1'b1;
        @(negedge clk);
      end
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == n - 1); in_sample = SW'(smp[i]);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    check("R9", "busy after last sample", {31'd0, busy}, 32'd1);
    if (poke) begin
      in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_sample = 14'd9000;
      repeat (6) @(negedge clk);
      check("R9", "busy held during ignored input", {31'd0, busy}, 32'd1);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    end
    t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    if (t >= 5000) check("R9", "busy never fell", 32'd1, 32'd0);
    repeat (3) @(negedge clk);
    check({tag, "/R6"}, "expected words left unissued", 32'(qw.size()), 32'd0);
    qw.delete(); qt.delete();
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R10", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R10", "busy in reset", {31'd0, busy}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R10", "busy after reset", {31'd0, busy}, 32'd0);

    // R1: nothing over, values equal to threshold stay skipped
    for (int i = 0; i < 20; i++) smp[i] = (i % 3 == 0) ? 100 : 50;
    run_window("R1", 20, 1'b0, 100, 2, 2, 1'b0, 1'b0);

    // R2: look-back only
    for (int i = 0; i < 30; i++) smp[i] = (i >= 10 && i <= 12) ? 200 + i : 10 + i;
    run_window("R2", 30, 1'b0, 100, 4, 0, 1'b0, 1'b0);

    // R3: look-forward only
    for (int i = 0; i < 30; i++) smp[i] = (i == 10 || i == 11) ? 300 + i : 20 + i;
    run_window("R3", 30, 1'b0, 100, 0, 5, 1'b0, 1'b0);

    // R4: no extension, isolated over samples
    for (int i = 0; i < 24; i++) smp[i] = (i == 3 || i == 4 || i == 17) ? 150 + i : 30;
    run_window("R4", 24, 1'b0, 100, 0, 0, 1'b0, 1'b0);

    // R1: negative polarity, dips below threshold
    for (int i = 0; i < 20; i++) smp[i] = (i >= 8 && i <= 10) ? 100 + i : 500 - i;
    smp[15] = 300;
    run_window("R1", 20, 1'b1, 300, 1, 1, 1'b0, 1'b0);

    // R5: extensions touch, then extensions overlap
    for (int i = 0; i < 40; i++) smp[i] = (i == 5 || i == 12 || i == 30 || i == 33) ? 400 + i : i;
    run_window("R5", 40, 1'b0, 100, 3, 3, 1'b0, 1'b0);

    // R2 and R3 clipped at both window edges
    for (int i = 0; i < 25; i++) smp[i] = (i == 1 || i == 23) ? 700 : 40 + i;
    run_window("R2", 25, 1'b0, 100, 5, 6, 1'b0, 1'b0);

    // R8: everything good, odd length
    for (int i = 0; i < 7; i++) smp[i] = 1000 + 17 * i;
    run_window("R8", 7, 1'b0, 100, 2, 0, 1'b0, 1'b0);

    // R2/R3: largest look-back, long look-forward
    for (int i = 0; i < 60; i++) smp[i] = (i == 30) ? 16000 : 3 * i % 90;
    run_window("R3", 60, 1'b0, 100, 15, 20, 1'b0, 1'b0);

    // R11: idle cycles inside the window
    for (int i = 0; i < 30; i++) smp[i] = (i >= 10 && i <= 12) ? 200 + i : 10 + i;
    run_window("R11", 30, 1'b0, 100, 4, 2, 1'b1, 1'b0);

    // R9: input offered while busy is ignored
    for (int i = 0; i < 30; i++) smp[i] = (i == 10 || i == 11) ? 300 + i : 20 + i;
    run_window("R9", 30, 1'b0, 100, 1, 5, 1'b0, 1'b1);

    // R8: one-sample window
    smp[0] = 5000;
    run_window("R8", 1, 1'b0, 100, 3, 3, 1'b0, 1'b0);

    // R7: ramp crossing the threshold repeatedly, many runs
    for (int i = 0; i < 64; i++) smp[i] = (i % 9) * 30;
    run_window("R7", 64, 1'b0, 100, 1, 0, 1'b0, 1'b0);

    finish_up();
  end
endmodule